// File: doc/BRIEF.md
# Banked Configuration and Status Register File

This block is one bank of memory-mapped registers on a narrow register bus. It sits between that bus and a peripheral. The peripheral receives its settings from the bank's control outputs, and the bank samples the peripheral's status inputs. The upper bits of the bus address carry a bank number. The bank claims an access only when that number equals its `BANK_ID` parameter. The remaining low bits choose one data-width slice inside the bank.

A register can be wider than the bus data width. Such a register takes several consecutive slice addresses. The slice with the most significant bits comes first, at the lowest address. All registers sit back to back in index order, so the bank is one contiguous run of slices. Parameters set the width of each register, whether it is a writable control register or a read-only status register, and the reset value of each control register. A write completes in a single clock edge. Read data is registered and appears one cycle after the address.

Top module: `csr_bank`

## Requirements
- R1: The bank is selected only when `csr_adr_i[ADDR_W-1:BANK_LSB]` equals `BANK_ID` (BANK_LSB = 9 by default). Any other address reads as zero and leaves every control register unchanged when written.
- R2: The slice offset is the full field `csr_adr_i[BANK_LSB-1:0]`. An offset at or beyond the total slice count reads as zero and is ignored on write, even inside the selected bank.
- R3: Registers are placed back to back in index order. Register i uses ceil(width/DATA_W) slices. The default map with DATA_W = 8 is: register 0, 16-bit control, slices 0-1; register 1, 8-bit control, slice 2; register 2, 24-bit status, slices 3-5; register 3, 12-bit control, slices 6-7. Bus address 0x0805 therefore selects the low byte of register 2.
- R4: Slices are in big-endian order: the slice at offset k of a register with S slices carries bits [(S-1-k)*DATA_W +: DATA_W]. Bit positions at or above the register width read as zero and ignore writes.
- R5: When `csr_we_i` is high at a rising clock edge and the address selects a control slice, that slice takes `csr_dat_w_i`. The new value appears on `ctrl_o` after that edge.
- R6: A slice write changes only the bits of that slice. The other slices of the same register and all other registers keep their values.
- R7: `csr_dat_r_o` is registered. After an edge it shows the slice addressed in the cycle before that edge, and it holds its previous value until the next edge.
- R8: Status registers are read-only. Writes to their slices change nothing. A read returns the `stat_i` bits present in the cycle the read is captured. `stat_i` bits that belong to control registers or lie above a status register's width are never visible.
- R9: An asynchronous active-low reset loads each control register with its reset value truncated to its width (defaults 0xA55A, 0x3C, 0x123) and clears `csr_dat_r_o`. `ctrl_o` holds register i at bits [i*32 +: 32]. Its status and padding positions are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_adr_i | input | ADDR_W | Bus address: bank number above BANK_LSB, slice offset below |
| csr_we_i | input | 1 | Write strobe |
| csr_dat_w_i | input | DATA_W | Write data for one slice |
| csr_dat_r_o | output | DATA_W | Registered read data of the addressed slice |
| ctrl_o | output | NUM_REGS*REG_MAX_W | Control register values, 32-bit lane per register |
| stat_i | input | NUM_REGS*REG_MAX_W | Status values from the peripheral, 32-bit lane per register |

## Verification
The bound checker watches the following on every cycle:
- Addresses outside the bank, or beyond the last slice, yield zero read data one cycle later.
- Control outputs stay still in any cycle without a selected write.
- A write never changes more than one slice's worth of control bits.

Some behaviours only the directed scenarios can show. These are the big-endian slice order, the exact default map with its padding bits, and the one-cycle read latency. They also include the live sampling of status inputs and the fact that status writes are ignored. Each of these needs the bench to know the expected register contents.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

    // Number of bus slices needed to hold a register of width w.
    function automatic int unsigned slices_for(int unsigned w, int unsigned dw);
        return (w + dw - 1) / dw;
    endfunction

    // Bits of a chunk starting at bit lo that lie below the register width.
    function automatic logic [31:0] chunk_mask(int unsigned w, int unsigned lo);
        logic [31:0] m;
        for (int unsigned b = 0; b < 32; b++) begin
            m[b] = (lo + b) < w;
        end
        return m;
    endfunction

endpackage

// File: rtl/csr_bank_decode.sv
module csr_bank_decode #(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned BANK_LSB = 9,
    parameter int unsigned BANK_ID  = 4,
    parameter int unsigned TOTAL    = 8
) (
    input  logic [ADDR_W-1:0] adr_i,
    output logic              bank_hit_o,
    output logic [TOTAL-1:0]  slice_hit_o
);
    localparam int unsigned ID_W = ADDR_W - BANK_LSB;

    logic [BANK_LSB-1:0] offset;

    always_comb begin
        bank_hit_o = (adr_i[ADDR_W-1:BANK_LSB] == ID_W'(BANK_ID));
        offset     = adr_i[BANK_LSB-1:0];
    end

    // One select line per slice; out-of-range offsets raise none.
    for (genvar j = 0; j < TOTAL; j++) begin : g_slice
        assign slice_hit_o[j] = bank_hit_o && (offset == BANK_LSB'(j));
    end

endmodule

// File: rtl/csr_bank_ctrl.sv
module csr_bank_ctrl
    import csr_bank_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned NUM_REGS  = 4,
    parameter int unsigned REG_MAX_W = 32,
    parameter int unsigned TOTAL     = 8,
    parameter int unsigned REG_W [NUM_REGS] = '{default: 8},
    parameter logic [NUM_REGS-1:0] REG_IS_STAT = '0,
    parameter logic [NUM_REGS*REG_MAX_W-1:0] REG_RST = '0
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          we_i,
    input  logic [DATA_W-1:0]             dat_w_i,
    input  logic [TOTAL-1:0]              slice_hit_i,
    output logic [NUM_REGS*REG_MAX_W-1:0] ctrl_o
);
    localparam int unsigned CHUNKS = REG_MAX_W / DATA_W;
    localparam int unsigned VEC_W  = NUM_REGS * REG_MAX_W;

    function automatic int unsigned off_of(int unsigned idx);
        int unsigned acc;
        acc = 0;
        for (int unsigned r = 0; r < NUM_REGS; r++) begin
            if (r < idx) acc += slices_for(REG_W[r], DATA_W);
        end
        return acc;
    endfunction

    function automatic logic [VEC_W-1:0] live_mask();
        logic [VEC_W-1:0] m;
        for (int unsigned r = 0; r < NUM_REGS; r++) begin
            for (int unsigned b = 0; b < REG_MAX_W; b++) begin
                m[r*REG_MAX_W + b] = !REG_IS_STAT[r] && (b < REG_W[r]);
            end
        end
        return m;
    endfunction

    localparam logic [VEC_W-1:0] LIVE = live_mask();

    typedef struct packed {
        logic [VEC_W-1:0] ctrl;
    } state_t;

    state_t           s_d, s_q;
    logic [VEC_W-1:0] wr_mask;
    logic [VEC_W-1:0] wdata_rep;

    // Chunk p of a register sits at bits p*DATA_W; its slice address is
    // OFF + NS-1-p (big-endian slice order).
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam int unsigned NS  = slices_for(REG_W[i], DATA_W);
        localparam int unsigned OFF = off_of(i);
        for (genvar p = 0; p < CHUNKS; p++) begin : g_chunk
            localparam logic [DATA_W-1:0] CM = DATA_W'(chunk_mask(REG_W[i], p*DATA_W));
            if (!REG_IS_STAT[i] && (p < NS)) begin : g_live
                assign wr_mask[i*REG_MAX_W + p*DATA_W +: DATA_W] =
                    {DATA_W{we_i && slice_hit_i[OFF + NS - 1 - p]}} & CM;
            end else begin : g_dead
                assign wr_mask[i*REG_MAX_W + p*DATA_W +: DATA_W] = '0;
            end
        end
    end

    always_comb begin
        wdata_rep = {(NUM_REGS*CHUNKS){dat_w_i}};
        s_d.ctrl  = (s_q.ctrl & ~wr_mask) | (wdata_rep & wr_mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.ctrl <= REG_RST & LIVE;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_o = s_q.ctrl;

endmodule

// File: rtl/csr_bank_rdmux.sv
module csr_bank_rdmux
    import csr_bank_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned NUM_REGS  = 4,
    parameter int unsigned REG_MAX_W = 32,
    parameter int unsigned TOTAL     = 8,
    parameter int unsigned REG_W [NUM_REGS] = '{default: 8},
    parameter logic [NUM_REGS-1:0] REG_IS_STAT = '0
) (
    input  logic [NUM_REGS*REG_MAX_W-1:0] ctrl_i,
    input  logic [NUM_REGS*REG_MAX_W-1:0] stat_i,
    input  logic [TOTAL-1:0]              slice_hit_i,
    output logic [DATA_W-1:0]             rd_o
);
    localparam int unsigned CHUNKS = REG_MAX_W / DATA_W;
    localparam int unsigned VEC_W  = NUM_REGS * REG_MAX_W;

    function automatic int unsigned off_of(int unsigned idx);
        int unsigned acc;
        acc = 0;
        for (int unsigned r = 0; r < NUM_REGS; r++) begin
            if (r < idx) acc += slices_for(REG_W[r], DATA_W);
        end
        return acc;
    endfunction

    logic [VEC_W-1:0] contrib;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam int unsigned NS  = slices_for(REG_W[i], DATA_W);
        localparam int unsigned OFF = off_of(i);
        logic [REG_MAX_W-1:0] view;
        if (REG_IS_STAT[i]) begin : g_stat
            assign view = stat_i[i*REG_MAX_W +: REG_MAX_W];
        end else begin : g_ctrl
            assign view = ctrl_i[i*REG_MAX_W +: REG_MAX_W];
        end
        for (genvar p = 0; p < CHUNKS; p++) begin : g_chunk
            localparam logic [DATA_W-1:0] CM = DATA_W'(chunk_mask(REG_W[i], p*DATA_W));
            if (p < NS) begin : g_live
                assign contrib[i*REG_MAX_W + p*DATA_W +: DATA_W] =
                    {DATA_W{slice_hit_i[OFF + NS - 1 - p]}} & view[p*DATA_W +: DATA_W] & CM;
            end else begin : g_dead
                assign contrib[i*REG_MAX_W + p*DATA_W +: DATA_W] = '0;
            end
        end
    end

    // At most one chunk is selected, so an OR tree forms the read mux.
    always_comb begin
        rd_o = '0;
        for (int unsigned c = 0; c < NUM_REGS*CHUNKS; c++) begin
            rd_o = rd_o | contrib[c*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_bank_pkg::*;
#(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned BANK_LSB  = 9,
    parameter int unsigned BANK_ID   = 4,
    parameter int unsigned NUM_REGS  = 4,
    parameter int unsigned REG_MAX_W = 32,
    parameter int unsigned REG_W [NUM_REGS] = '{16, 8, 24, 12},
    parameter logic [NUM_REGS-1:0] REG_IS_STAT = 4'b0100,
    parameter logic [NUM_REGS*REG_MAX_W-1:0] REG_RST =
        {32'h0000_0123, 32'h0000_0000, 32'h0000_003C, 32'h0000_A55A}
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [ADDR_W-1:0]             csr_adr_i,
    input  logic                          csr_we_i,
    input  logic [DATA_W-1:0]             csr_dat_w_i,
    output logic [DATA_W-1:0]             csr_dat_r_o,
    output logic [NUM_REGS*REG_MAX_W-1:0] ctrl_o,
    input  logic [NUM_REGS*REG_MAX_W-1:0] stat_i
);
    function automatic int unsigned off_of(int unsigned idx);
        int unsigned acc;
        acc = 0;
        for (int unsigned r = 0; r < NUM_REGS; r++) begin
            if (r < idx) acc += slices_for(REG_W[r], DATA_W);
        end
        return acc;
    endfunction

    localparam int unsigned TOTAL_SLICES = off_of(NUM_REGS);

    typedef struct packed {
        logic [DATA_W-1:0] dat_r;
    } state_t;

    state_t                   s_d, s_q;
    logic                     bank_hit;
    logic [TOTAL_SLICES-1:0]  slice_hit;
    logic [DATA_W-1:0]        rd_data;

    csr_bank_decode #(
        .ADDR_W   (ADDR_W),
        .BANK_LSB (BANK_LSB),
        .BANK_ID  (BANK_ID),
        .TOTAL    (TOTAL_SLICES)
    ) u_decode (
        .adr_i       (csr_adr_i),
        .bank_hit_o  (bank_hit),
        .slice_hit_o (slice_hit)
    );

    csr_bank_ctrl #(
        .DATA_W      (DATA_W),
        .NUM_REGS    (NUM_REGS),
        .REG_MAX_W   (REG_MAX_W),
        .TOTAL       (TOTAL_SLICES),
        .REG_W       (REG_W),
        .REG_IS_STAT (REG_IS_STAT),
        .REG_RST     (REG_RST)
    ) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (csr_we_i & bank_hit),
        .dat_w_i     (csr_dat_w_i),
        .slice_hit_i (slice_hit),
        .ctrl_o      (ctrl_o)
    );

    csr_bank_rdmux #(
        .DATA_W      (DATA_W),
        .NUM_REGS    (NUM_REGS),
        .REG_MAX_W   (REG_MAX_W),
        .TOTAL       (TOTAL_SLICES),
        .REG_W       (REG_W),
        .REG_IS_STAT (REG_IS_STAT)
    ) u_rdmux (
        .ctrl_i      (ctrl_o),
        .stat_i      (stat_i),
        .slice_hit_i (slice_hit),
        .rd_o        (rd_data)
    );

    always_comb begin
        s_d       = s_q;
        s_d.dat_r = rd_data;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign csr_dat_r_o = s_q.dat_r;

endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned BANK_LSB = 9,
    parameter int unsigned BANK_ID  = 4,
    parameter int unsigned TOTAL    = 8,
    parameter int unsigned CTRL_W   = 128
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] csr_adr_i,
    input logic              csr_we_i,
    input logic [DATA_W-1:0] csr_dat_r_o,
    input logic [CTRL_W-1:0] ctrl_o
);
    localparam int unsigned ID_W = ADDR_W - BANK_LSB;

    logic in_bank;
    logic past_end;

    always_comb begin
        in_bank  = csr_adr_i[ADDR_W-1:BANK_LSB] == ID_W'(BANK_ID);
        past_end = csr_adr_i[BANK_LSB-1:0] >= BANK_LSB'(TOTAL);
    end

    // R1: a foreign bank number gives zero read data on the next cycle
    assert_foreign_bank_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_bank |=> (csr_dat_r_o == '0));

    // R2: offsets past the last slice read as zero
    assert_past_end_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_bank && past_end) |=> (csr_dat_r_o == '0));

    // R5: control outputs move only after a selected, in-range write
    assert_ctrl_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!csr_we_i || !in_bank || past_end) |=> $stable(ctrl_o));

    // R6: one write touches at most one slice worth of control bits
    assert_one_slice_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_we_i |=> ($countones(ctrl_o ^ $past(ctrl_o)) <= DATA_W));

endmodule

bind csr_bank csr_bank_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BANK_LSB (BANK_LSB),
    .BANK_ID  (BANK_ID),
    .TOTAL    (TOTAL_SLICES),
    .CTRL_W   (NUM_REGS*REG_MAX_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csr_adr_i   (csr_adr_i),
    .csr_we_i    (csr_we_i),
    .csr_dat_r_o (csr_dat_r_o),
    .ctrl_o      (ctrl_o)
);

// File: tb/csr_bank_tb_top.sv
module csr_bank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic [13:0]  adr = '0;
    logic         we = 1'b0;
    logic [7:0]   dat_w = '0;
    logic [7:0]   dat_r;
    logic [127:0] ctrl;
    logic [127:0] stat = '0;

    logic [127:0] exp_ctrl;
    int           n_vec = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    csr_bank dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .csr_adr_i   (adr),
        .csr_we_i    (we),
        .csr_dat_w_i (dat_w),
        .csr_dat_r_o (dat_r),
        .ctrl_o      (ctrl),
        .stat_i      (stat)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [13:0] a, input logic [7:0] d);
        @(negedge clk_i);
        adr = a; we = 1'b1; dat_w = d;
        @(negedge clk_i);
        we = 1'b0;
    endtask

    task automatic csr_read(input logic [13:0] a, output logic [7:0] d);
        @(negedge clk_i);
        adr = a; we = 1'b0;
        @(negedge clk_i);
        d = dat_r;
    endtask

    task automatic t_reset();
        exp_ctrl = {32'h0000_0123, 32'h0, 32'h0000_003C, 32'h0000_A55A};
        check("R9 ctrl reset", ctrl, exp_ctrl);
        check("R9 dat_r reset", {120'b0, dat_r}, 128'h0);
    endtask

    task automatic t_latency();
        logic [7:0] d;
        csr_read(14'h0802, d);
        check("R7 first read", {120'b0, d}, 128'h3C);
        adr = 14'h0800;
        #1;
        check("R7 held before edge", {120'b0, dat_r}, 128'h3C);
        @(negedge clk_i);
        check("R7 after edge", {120'b0, dat_r}, 128'hA5);
    endtask

    task automatic t_map();
        logic [7:0] d;
        logic [7:0] want [8] = '{8'hA5, 8'h5A, 8'h3C, 8'hC0, 8'hFF, 8'hEE, 8'h01, 8'h23};
        for (int j = 0; j < 8; j++) begin
            csr_read(14'h0800 | 14'(j), d);
            check("R3 R4 slice map", {120'b0, d}, {120'b0, want[j]});
        end
        csr_read(14'h0805, d);
        check("R3 address 0x0805", {120'b0, d}, 128'hEE);
    endtask

    task automatic t_write();
        logic [7:0] d;
        csr_write(14'h0801, 8'h77);
        exp_ctrl[15:0] = 16'hA577;
        check("R5 R6 low slice write", ctrl, exp_ctrl);
        csr_write(14'h0800, 8'h12);
        exp_ctrl[15:0] = 16'h1277;
        check("R6 high slice write", ctrl, exp_ctrl);
        csr_read(14'h0800, d);
        check("R4 readback high", {120'b0, d}, 128'h12);
        csr_read(14'h0801, d);
        check("R4 readback low", {120'b0, d}, 128'h77);
        csr_write(14'h0802, 8'hC3);
        exp_ctrl[39:32] = 8'hC3;
        check("R5 single slice reg", ctrl, exp_ctrl);
    endtask

    task automatic t_pad();
        logic [7:0] d;
        csr_write(14'h0806, 8'hFF);
        exp_ctrl[107:96] = 12'hF23;
        check("R4 pad bits dropped", ctrl, exp_ctrl);
        csr_read(14'h0806, d);
        check("R4 pad bits read zero", {120'b0, d}, 128'h0F);
        csr_write(14'h0807, 8'h00);
        exp_ctrl[107:96] = 12'hF00;
        check("R6 low slice of 12-bit", ctrl, exp_ctrl);
    endtask

    task automatic t_status();
        logic [7:0] d;
        csr_write(14'h0804, 8'h00);
        check("R8 status write ignored ctrl", ctrl, exp_ctrl);
        csr_read(14'h0804, d);
        check("R8 status write ignored read", {120'b0, d}, 128'hFF);
        stat[95:64] = 32'hAB12_3456;
        stat[31:0]  = 32'hFFFF_FFFF;
        csr_read(14'h0803, d);
        check("R8 live status top slice", {120'b0, d}, 128'h12);
        csr_read(14'h0805, d);
        check("R8 live status low slice", {120'b0, d}, 128'h56);
        csr_read(14'h0800, d);
        check("R8 stat lane of ctrl reg hidden", {120'b0, d}, 128'h12);
    endtask

    task automatic t_miss();
        logic [7:0] d;
        csr_write(14'h0A00, 8'h00);
        csr_write(14'h0000, 8'h00);
        csr_write(14'h2801, 8'h00);
        check("R1 foreign writes ignored", ctrl, exp_ctrl);
        csr_read(14'h0A00, d);
        check("R1 bank 5 reads zero", {120'b0, d}, 128'h0);
        csr_read(14'h0005, d);
        check("R1 bank 0 reads zero", {120'b0, d}, 128'h0);
        csr_read(14'h2800, d);
        check("R1 upper id bits", {120'b0, d}, 128'h0);
    endtask

    task automatic t_oob();
        logic [7:0] d;
        csr_write(14'h0808, 8'h00);
        csr_write(14'h09FF, 8'h00);
        check("R2 past-end writes ignored", ctrl, exp_ctrl);
        csr_read(14'h0808, d);
        check("R2 offset 8 reads zero", {120'b0, d}, 128'h0);
        csr_read(14'h09FF, d);
        check("R2 offset 511 reads zero", {120'b0, d}, 128'h0);
        csr_read(14'h0802, d);
        check("R2 in-range after", {120'b0, d}, 128'hC3);
    endtask

    initial begin
        stat[95:64] = 32'h00C0_FFEE;
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        t_latency();
        t_map();
        t_write();
        t_pad();
        t_status();
        t_miss();
        t_oob();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule